// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned N-bit operands and drives the 2N-bit product with no clock. The design is recursive. Each level splits both operands into a low half and a high half. Four half-width multipliers then form the four cross products. The recursion stops at a 2×2 cell, which builds its product bits one column at a time: the vertical bit products and the crosswise bit products of a column are added, and that column's carry passes to the next column.

At each level one row of full adders reduces three operands of 3N/2 bits to a sum vector and a carry vector:
- the high×high product placed above the upper half of the low×low product;
- the high×low product, zero-extended;
- the low×high product, zero-extended.

One carry-propagate addition of the sum vector and the carry vector shifted left by one gives the upper product bits. The lowest N/2 product bits come straight from the low×low product.

The block is meant to sit in a datapath as a purely combinational unit. Registers around it belong to the surrounding logic.

Top module: `vedic_mult`

## Requirements
- R1: For every pair of unsigned operands, `p_o` equals `a_i * b_i`. This holds for N = 4 (8-bit product) and N = 8 (16-bit product).
- R2: Product bit 0 equals the AND of the two operand LSBs.
- R3: Product bits [N/2-1:0] equal the low N/2 bits of the product of the low operand halves.
- R4: If either operand is zero, the product is zero.
- R5: If one operand is 1, the product equals the other operand, zero-extended.
- R6: All-ones times all-ones gives (2^N-1)^2. The carry-propagate addition at every level produces no carry out of its 3N/2-bit result.
- R7: The 2×2 base cell returns the correct 4-bit product for all 16 operand pairs. With N = 2, the top module is the base cell.
- R8: The product does not depend on operand order: p(a,b) = p(b,a).
- R9: At every level, the carry-save row keeps the arithmetic sum: sum + 2·carry equals the sum of its three inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| p_o | output | 2N | Unsigned product |

## Verification
The two functions that meet in the same evaluation are the direct pass-through of the low product bits and the carry-save merge of the upper bits. Both depend on the low×low sub-product at once, so an error in how that sub-product is split or overlapped would show on the boundary bit N/2. The bench drives every operand pair for N = 2, 4 and 8, so every carry pattern that crosses that boundary occurs. It compares the full product against an independent `a*b`, and the low bits against a separately computed low-half product. Random pairs with the operands swapped, together with the zero, one and all-ones corners, add the order-independence and overflow checks.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int unsigned VM_BASE_W = 2;

  function automatic bit vm_width_ok(int unsigned w);
    int unsigned v = w;
    if (w < VM_BASE_W) return 1'b0;
    while (v > 1) begin
      if (v[0]) return 1'b0;
      v = v >> 1;
    end
    return 1'b1;
  endfunction
endpackage

// File: rtl/vm_base2x2.sv
module vm_base2x2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic v0, x10, x01, v1, k1;

  always_comb begin
    v0  = a_i[0] & b_i[0];
    x10 = a_i[1] & b_i[0];
    x01 = a_i[0] & b_i[1];
    v1  = a_i[1] & b_i[1];
    k1  = x10 & x01;            // column-1 carry
    p_o = {v1 & k1, v1 ^ k1, x10 ^ x01, v0};
  end

  // p_base_exact_r7
  always_comb begin
    if (!$isunknown({a_i, b_i}))
      p_base_exact_r7: assert (p_o == 4'(a_i) * 4'(b_i))
        else $error("base cell product wrong");
  end
endmodule

// File: rtl/vm_csa_row.sv
module vm_csa_row #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    assign c_o[i] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
  end

  always_comb begin
    if (!$isunknown({x_i, y_i, z_i}))
      p_csa_conserve_r9: assert (({2'b0, s_o} + {1'b0, c_o, 1'b0}) ==
                                 ({2'b0, x_i} + {2'b0, y_i} + {2'b0, z_i}))
        else $error("carry-save row lost value");
  end
endmodule

// File: rtl/vm_node.sv
module vm_node #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H = W / 2;
  localparam int unsigned S = 3 * H;

  if (W == vm_pkg::VM_BASE_W) begin : g_leaf
    vm_base2x2 u_base (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    logic [W-1:0] m1, m2, m3, m4;
    logic [S-1:0] opx, opy, opz, sv, cv;
    logic [S:0]   total;

    vm_node #(.W(H)) u_m1 (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(m1));
    vm_node #(.W(H)) u_m2 (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(m2));
    vm_node #(.W(H)) u_m3 (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(m3));
    vm_node #(.W(H)) u_m4 (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(m4));

    assign opx = {m4, m1[W-1:H]};
    assign opy = {{H{1'b0}}, m2};
    assign opz = {{H{1'b0}}, m3};

    vm_csa_row #(.W(S)) u_csa (
      .x_i(opx), .y_i(opy), .z_i(opz), .s_o(sv), .c_o(cv)
    );

    assign total = {1'b0, sv} + {cv, 1'b0};
    assign p_o   = {total[S-1:0], m1[H-1:0]};

    always_comb begin
      if (!$isunknown({a_i, b_i})) begin
        p_no_overflow_r6: assert (total[S] == 1'b0)
          else $error("carry out of merge");
        p_low_pass_r3: assert (p_o[H-1:0] == H'((W'(a_i[H-1:0])) * (W'(b_i[H-1:0]))))
          else $error("low product bits wrong");
      end
    end
  end
endmodule

// File: rtl/vedic_mult.sv
module vedic_mult #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  initial begin
    p_width_legal_r1: assert (vm_pkg::vm_width_ok(N))
      else $error("N must be a power of two, at least 2");
  end

  vm_node #(.W(N)) u_core (.a_i(a_i), .b_i(b_i), .p_o(p_o));

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      p_lsb_and_r2: assert (p_o[0] == (a_i[0] & b_i[0]))
        else $error("product lsb wrong");
      p_zero_r4: assert (!((a_i == '0) || (b_i == '0)) || (p_o == '0))
        else $error("zero operand gave nonzero product");
      p_unit_r5: assert (!(a_i == N'(1)) || (p_o == {{N{1'b0}}, b_i}))
        else $error("unit operand not passed through");
    end
  end
endmodule

// File: tb/sim_vedic_mult.sv
module sim_vedic_mult;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [1:0] a2, b2; logic [3:0]  p2;
  logic [3:0] a4, b4; logic [7:0]  p4;
  logic [7:0] a8, b8; logic [15:0] p8;

  vedic_mult #(.N(2)) u2 (.a_i(a2), .b_i(b2), .p_o(p2));
  vedic_mult #(.N(4)) u1 (.a_i(a4), .b_i(b4), .p_o(p4));
  vedic_mult #(.N(8)) u0 (.a_i(a8), .b_i(b8), .p_o(p8));

  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [15:0] ref_mul(int unsigned a, int unsigned b);
    return 16'(a * b);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] b);
    @(posedge clk);
    a8 = a; b8 = b; a4 = a[3:0]; b4 = b[3:0]; a2 = a[1:0]; b2 = b[1:0];
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    void'($urandom(32'd20240611));
    a2 = '0; b2 = '0; a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R4 idle", p8, 16'h0);

    // R7 base cell, all pairs
    for (int i = 0; i < 16; i++) begin
      drive(8'(i >> 2), 8'(i & 3));
      check("R7", {12'h0, p2}, ref_mul(i >> 2, i & 3));
    end
    // R1 R2 R3 exhaustive N=4
    for (int i = 0; i < 256; i++) begin
      drive(8'(i >> 4), 8'(i & 15));
      check("R1 n4", {8'h0, p4}, ref_mul(i >> 4, i & 15));
      check("R3 n4", {14'h0, p4[1:0]}, {14'h0, 2'(ref_mul((i >> 4) & 3, i & 3))});
    end
    // R1 R2 R3 exhaustive N=8
    for (int i = 0; i < 65536; i++) begin
      drive(8'(i >> 8), 8'(i & 255));
      check("R1 n8", p8, ref_mul(i >> 8, i & 255));
      if ((i & 255) == 0) begin
        check("R2", {15'h0, p8[0]}, {15'h0, 1'(((i >> 8) & 1) & (i & 1))});
        check("R3 n8", {12'h0, p8[3:0]}, {12'h0, 4'(ref_mul((i >> 8) & 15, i & 15))});
      end
    end
    // directed corners
    drive(8'h00, 8'hff); check("R4", p8, 16'h0);
    drive(8'hff, 8'h00); check("R4", p8, 16'h0);
    drive(8'h01, 8'hb7); check("R5", p8, 16'h00b7);
    drive(8'h5c, 8'h01); check("R5", p8, 16'h005c);
    drive(8'hff, 8'hff); check("R6 n8", p8, 16'hfe01);
    check("R6 n4", {8'h0, p4}, 16'h00e1);
    check("R6 n2", {12'h0, p2}, 16'h0009);
    // R8 random commutation
    for (int k = 0; k < 500; k++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom); rb = 8'($urandom);
      drive(ra, rb); keep = p8;
      drive(rb, ra);
      check("R8", p8, keep);
      check("R1 rnd", p8, ref_mul(ra, rb));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule